// File: doc/BRIEF.md
# Register renaming map unit

This block sits after instruction decode and translates the architectural register names of one instruction per cycle into tags of a larger physical register file. It keeps a table with one physical tag for each logical register and a first-in first-out queue of physical registers that currently hold no live value. Every instruction that writes a register is given a fresh physical register, so two instructions that share only a destination name, or where a later one overwrites a register an earlier one still reads, no longer conflict.

The source lookup is combinational and uses the table as it stands before the current instruction's own update. The destination tag is the head of the free queue, presented in the same cycle. The table entry and the queue change at the next clock edge. A separate release port lets the retirement logic hand a physical register back, and it is appended at the tail of the queue. If a destination is requested while the queue is empty, the block raises a stall and leaves its state unchanged, so the same instruction can be presented again.

Top module: `rename_unit`

## Requirements
- R1: After reset, logical register i maps to physical register i, and the free queue holds the tags NUM_LOG to NUM_PHYS-1 in ascending order, so the first allocations return NUM_LOG, NUM_LOG+1, and so on.
- R2: phys_a_o and phys_b_o give the table entries of src_a_i and src_b_i combinationally, read before the current instruction's update, so an instruction whose source equals its destination reads the old tag.
- R3: An allocation happens when dec_valid_i and dst_valid_i are 1, dst_i is not 0 and the queue is not empty. phys_dst_o then shows the queue head, and that tag leaves the queue at the clock edge.
- R4: One cycle after an allocation, the table entry of the destination is the newly allocated tag.
- R5: Successive allocations return distinct tags in queue order, including writes to logical registers that are related only by name.
- R6: Logical register 0 always reads physical tag 0. A write to logical register 0 allocates nothing and leaves phys_dst_o at 0.
- R7: When an allocation is requested with the queue empty, stall_o is 1, and neither the table nor the queue changes.
- R8: When rel_valid_i is 1, rel_tag_i is appended at the tail of the queue. A release and an allocation in the same cycle both take effect, and a release in a stalled cycle is still accepted.
- R9: When no allocation happens, phys_dst_o is 0 and stall_o is 0 unless R7 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | A decoded instruction is present |
| src_a_i | input | LW | First logical source |
| src_b_i | input | LW | Second logical source |
| dst_i | input | LW | Logical destination |
| dst_valid_i | input | 1 | Instruction writes dst_i |
| rel_valid_i | input | 1 | Return a physical register to the queue |
| rel_tag_i | input | PW | Physical tag being returned |
| phys_a_o | output | PW | Physical tag of the first source |
| phys_b_o | output | PW | Physical tag of the second source |
| phys_dst_o | output | PW | Newly allocated physical destination, 0 if none |
| stall_o | output | 1 | Destination requested with no free register |

## Verification
The two functions that can meet in one cycle are an allocation from the head of the free queue and a release onto its tail. The bench provokes the pairing by returning a previously superseded tag in the same cycle as a rename, both when the queue is non-empty and when it has been drained to zero, where the rename must stall while the release is still accepted. It judges the result from the tags handed out in the following cycles, which must follow a reference queue kept in the bench, and from the table contents read back through the source ports.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int unsigned DEF_LOG_REGS  = 8;
  localparam int unsigned DEF_PHYS_REGS = 16;

  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int unsigned NUM_LOG  = 8,
  parameter int unsigned NUM_PHYS = 16,
  parameter int unsigned NUM_RD   = 2,
  localparam int unsigned LW = $clog2(NUM_LOG),
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_RD-1:0][LW-1:0]  raddr_i,
  output logic [NUM_RD-1:0][PW-1:0]  rdata_o,
  input  logic                       we_i,
  input  logic [LW-1:0]              waddr_i,
  input  logic [PW-1:0]              wdata_i
);
  logic [PW-1:0] map_q [NUM_LOG];

  // entry 0 is constant zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_LOG; i++) map_q[i] <= PW'(i);
    end else if (we_i && (waddr_i != '0)) begin
      map_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    assign rdata_o[r] = (raddr_i[r] == '0) ? '0 : map_q[raddr_i[r]];
  end
endmodule

// File: rtl/rename_free_list.sv
module rename_free_list
  import rename_pkg::*;
#(
  parameter int unsigned NUM_LOG  = 8,
  parameter int unsigned NUM_PHYS = 16,
  localparam int unsigned PW    = $clog2(NUM_PHYS),
  localparam int unsigned DEPTH = NUM_PHYS,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1),
  localparam int unsigned NFREE = NUM_PHYS - NUM_LOG
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [PW-1:0] push_tag_i,
  input  logic          pop_i,
  output logic [PW-1:0] head_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);
  logic [PW-1:0] mem_q [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;
  assign pop_ok  = pop_i && !empty_o;
  assign push_ok = push_i && (cnt_q != CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++)
        mem_q[k] <= (k < NFREE) ? PW'(NUM_LOG + k) : '0;
      rd_q  <= '0;
      wr_q  <= AW'(NFREE % DEPTH);
      cnt_q <= CW'(NFREE);
    end else begin
      if (push_ok) begin
        mem_q[wr_q] <= push_tag_i;
        wr_q        <= AW'(wrap_inc(32'(wr_q), DEPTH));
      end
      if (pop_ok) rd_q <= AW'(wrap_inc(32'(rd_q), DEPTH));
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rename_unit.sv
module rename_unit
  import rename_pkg::*;
#(
  parameter int unsigned NUM_LOG  = DEF_LOG_REGS,
  parameter int unsigned NUM_PHYS = DEF_PHYS_REGS,
  localparam int unsigned LW = $clog2(NUM_LOG),
  localparam int unsigned PW = $clog2(NUM_PHYS),
  localparam int unsigned CW = $clog2(NUM_PHYS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dec_valid_i,
  input  logic [LW-1:0] src_a_i,
  input  logic [LW-1:0] src_b_i,
  input  logic [LW-1:0] dst_i,
  input  logic          dst_valid_i,
  input  logic          rel_valid_i,
  input  logic [PW-1:0] rel_tag_i,
  output logic [PW-1:0] phys_a_o,
  output logic [PW-1:0] phys_b_o,
  output logic [PW-1:0] phys_dst_o,
  output logic          stall_o
);
  logic                     want_dst, alloc;
  logic                     fl_empty;
  logic [PW-1:0]            fl_head;
  logic [CW-1:0]            fl_count;
  logic [1:0][LW-1:0]       rd_addr;
  logic [1:0][PW-1:0]       rd_data;

  assign want_dst = dec_valid_i && dst_valid_i && (dst_i != '0);
  assign alloc    = want_dst && !fl_empty;
  assign stall_o  = want_dst && fl_empty;

  assign rd_addr[0] = src_a_i;
  assign rd_addr[1] = src_b_i;
  assign phys_a_o   = rd_data[0];
  assign phys_b_o   = rd_data[1];
  assign phys_dst_o = alloc ? fl_head : '0;

  rename_map_table #(
    .NUM_LOG (NUM_LOG),
    .NUM_PHYS(NUM_PHYS),
    .NUM_RD  (2)
  ) i_map (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raddr_i(rd_addr),
    .rdata_o(rd_data),
    .we_i   (alloc),
    .waddr_i(dst_i),
    .wdata_i(fl_head)
  );

  rename_free_list #(
    .NUM_LOG (NUM_LOG),
    .NUM_PHYS(NUM_PHYS)
  ) i_free (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (rel_valid_i),
    .push_tag_i(rel_tag_i),
    .pop_i     (alloc),
    .head_o    (fl_head),
    .empty_o   (fl_empty),
    .count_o   (fl_count)
  );
endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
  parameter int unsigned LW = 3,
  parameter int unsigned PW = 4,
  parameter int unsigned CW = 5,
  parameter int unsigned NUM_PHYS = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dec_valid_i,
  input logic [LW-1:0] src_a_i,
  input logic [LW-1:0] src_b_i,
  input logic [LW-1:0] dst_i,
  input logic          dst_valid_i,
  input logic          rel_valid_i,
  input logic [PW-1:0] phys_a_o,
  input logic [PW-1:0] phys_b_o,
  input logic [PW-1:0] phys_dst_o,
  input logic          stall_o,
  input logic [CW-1:0] fl_count
);
  logic req, took;
  assign req  = dec_valid_i && dst_valid_i && (dst_i != '0);
  assign took = req && !stall_o;

  AST_ZERO_SRC_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_a_i == '0) |-> (phys_a_o == '0)); // R6
  AST_ZERO_SRC_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_b_i == '0) |-> (phys_b_o == '0)); // R6
  AST_STALL_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (fl_count == '0)); // R7
  AST_STALL_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !rel_valid_i) |=> (fl_count == '0)); // R7
  AST_NO_DST_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !took |-> (phys_dst_o == '0)); // R9
  AST_POP_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (took && !rel_valid_i) |=> (fl_count == $past(fl_count) - 1'b1)); // R3
  AST_SWAP_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (took && rel_valid_i) |=> $stable(fl_count)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_valid_i |-> (fl_count < CW'(NUM_PHYS))); // R8
  AST_MAP_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    took |=> ((src_a_i == $past(dst_i)) -> (phys_a_o == $past(phys_dst_o)))); // R4
endmodule

bind rename_unit rename_unit_chk #(
  .LW(LW), .PW(PW), .CW(CW), .NUM_PHYS(NUM_PHYS)
) i_rename_unit_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dec_valid_i(dec_valid_i),
  .src_a_i    (src_a_i),
  .src_b_i    (src_b_i),
  .dst_i      (dst_i),
  .dst_valid_i(dst_valid_i),
  .rel_valid_i(rel_valid_i),
  .phys_a_o   (phys_a_o),
  .phys_b_o   (phys_b_o),
  .phys_dst_o (phys_dst_o),
  .stall_o    (stall_o),
  .fl_count   (fl_count)
);

// File: tb/test_rename_unit.sv
module test_rename_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;
  localparam int NP = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dec_valid_i = 1'b0, dst_valid_i = 1'b0, rel_valid_i = 1'b0;
  logic [2:0] src_a_i = '0, src_b_i = '0, dst_i = '0;
  logic [3:0] rel_tag_i = '0;
  logic [3:0] phys_a_o, phys_b_o, phys_dst_o;
  logic       stall_o;

  int checks = 0, failures = 0;
  int emap [NL];
  int fq [NP];
  int fh, ft, fc;
  int pool [NP];
  int pc;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rename_unit i_rename_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .dec_valid_i(dec_valid_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .dst_i(dst_i), .dst_valid_i(dst_valid_i),
    .rel_valid_i(rel_valid_i), .rel_tag_i(rel_tag_i),
    .phys_a_o(phys_a_o), .phys_b_o(phys_b_o), .phys_dst_o(phys_dst_o), .stall_o(stall_o)
  );

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, exp, $time);
    end
  endtask

  function automatic int pool_take();
    int k = int'($urandom % pc);
    int t = pool[k];
    pool[k] = pool[pc-1];
    pc--;
    return t;
  endfunction

  task automatic step(input bit dv, input bit dvl, input int sa, input int sb, input int d,
                      input bit rv, input int rt, input string rq);
    bit want, al;
    @(negedge clk_i);
    dec_valid_i = dv; dst_valid_i = dvl;
    src_a_i = 3'(sa); src_b_i = 3'(sb); dst_i = 3'(d);
    rel_valid_i = rv; rel_tag_i = 4'(rt);
    #1;
    want = dv && dvl && (d != 0);
    al   = want && (fc > 0);
    chk({rq, " src_a"}, int'(phys_a_o), emap[sa]);
    chk({rq, " src_b"}, int'(phys_b_o), emap[sb]);
    chk({rq, " dst"}, int'(phys_dst_o), al ? fq[fh] : 0);
    chk({rq, " stall"}, int'(stall_o), (want && fc == 0) ? 1 : 0);
    @(posedge clk_i);
    if (al) begin
      pool[pc] = emap[d]; pc++;
      emap[d] = fq[fh];
      fh = (fh + 1) % NP; fc--;
    end
    if (rv) begin
      fq[ft] = rt; ft = (ft + 1) % NP; fc++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NL; i++) emap[i] = i;
    for (int k = 0; k < NP; k++) fq[k] = (k < NP - NL) ? NL + k : 0;
    fh = 0; ft = NP - NL; fc = NP - NL; pc = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1: reset map through the source ports
    for (int i = 0; i < NL; i++) step(0, 0, i, NL - 1 - i, 0, 0, 0, "R1");
    // R2 R3: add r3,r3,4 reads 3, writes 8
    step(1, 1, 3, 3, 3, 0, 0, "R2");
    // R4: r3 now maps to the new tag
    step(0, 0, 3, 0, 0, 0, 0, "R4");
    chk("R4 r3 map", int'(phys_a_o), 8);
    // R5: name-only related writes get 9,10,11
    step(1, 1, 2, 1, 1, 0, 0, "R5");
    step(1, 1, 1, 2, 2, 0, 0, "R5");
    step(1, 1, 1, 2, 1, 0, 0, "R5");
    chk("R5 third tag", int'(emap[1]), 11);
    // R6: write to r0 allocates nothing
    step(1, 1, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 4, 0, 0, 0, "R6");
    // R9: dst_valid low, dec_valid low
    step(1, 0, 4, 5, 4, 0, 0, "R9");
    step(0, 1, 4, 5, 4, 0, 0, "R9");
    // drain queue then R7 stall
    while (fc > 0) step(1, 1, 5, 6, 5, 0, 0, "R3");
    step(1, 1, 5, 6, 5, 0, 0, "R7");
    step(1, 1, 6, 5, 6, 0, 0, "R7");
    step(0, 0, 5, 6, 0, 0, 0, "R7");
    // R8: release during stall is kept, then reused
    step(1, 1, 7, 5, 7, 1, pool_take(), "R8");
    step(1, 1, 7, 5, 7, 0, 0, "R8");
    // R8: release and allocation in one cycle while non-empty
    step(0, 0, 0, 0, 0, 1, pool_take(), "R8");
    step(0, 0, 0, 0, 0, 1, pool_take(), "R8");
    step(1, 1, 2, 3, 2, 1, pool_take(), "R8");
    step(1, 1, 2, 3, 3, 0, 0, "R8");
    step(1, 1, 2, 3, 4, 0, 0, "R8");

    // constrained random mix
    for (int n = 0; n < 2000; n++) begin
      bit dv  = ($urandom % 4) != 0;
      bit dvl = ($urandom % 5) != 0;
      bit rv  = (pc > 0) && (($urandom % 3) == 0);
      int rt  = rv ? pool_take() : 0;
      step(dv, dvl, int'($urandom % NL), int'($urandom % NL), int'($urandom % NL),
           rv, rt, "R2");
    end
    // R1 R5 sanity: all mapped tags distinct and nonzero except r0
    for (int i = 1; i < NL; i++)
      for (int j = i + 1; j < NL; j++) begin
        step(0, 0, i, j, 0, 0, 0, "R5");
        checks++;
        if (phys_a_o == phys_b_o) begin
          failures++;
          $display("FAIL R5 actual=%0d expected=distinct from %0d", phys_a_o, phys_b_o);
        end
      end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule